// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Group

This block holds four down-counting timers behind a simple 32-bit register port. All four timers share one group control word. A free-running prescaler in the group divides the core clock by 8, 16, 32 or 64. It produces a one-cycle count enable, and every timer that is not chained steps on that enable. A timer steps only while the inhibit flag in its reload register is clear. When a standalone timer steps from zero, it reloads from its reload value and pulls its active-low, level interrupt line. The line stays low until software writes the timer's count register.

Software can join two neighbouring timers into one long counter. To do so it sets both the chain bit and the wrap bit of that pair in the control word. The lower timer then runs past zero to all ones instead of reloading, and it raises no interrupt. Each of those wraps steps the upper timer once, and the upper timer ignores the prescaler. The upper timer reloads and interrupts in the normal way, so the full period is roughly the upper count times 2^32. Each timer also has two 32-bit words that are plain storage for the interrupt routing logic next to it.

Top module: `tgrp_timer_group`

## Requirements
- R1: After a synchronous active-low reset, every count reads 0 and every reload register reads 0x8000_0000 (inhibited). The vector, destination and control words read 0, and every irq_n bit is 1.
- R2: The prescaler is one counter that runs freely from reset. It gives a count enable in each cycle where its low 3+S bits are all ones, with S = control[9:8]. The values 0, 1, 2 and 3 of S therefore give enables every 8, 16, 32 and 64 cycles.
- R3: While bit 31 of a timer's reload register is 1, that timer's count does not change except by a register write, and the timer raises no interrupt.
- R4: A running timer that is not the upper half of an active pair steps on each prescaler enable. A timer that is the upper half of an active pair steps on each wrap of its lower half instead. In both cases a step decrements a nonzero count. A step at count zero loads reload[30:0] (bit 31 cleared) and drives that timer's irq_n to 0, unless the timer is the lower half of an active pair.
- R5: An irq_n bit that has gone low stays low until a write to the count register of that same timer. That write sets the count to all 32 written bits and returns irq_n to 1.
- R6: A write to a reload register with bit 31 set also loads the written bits [30:0] into the count. A write with bit 31 clear leaves the count as it was.
- R7: A write to a timer's count or reload register takes the place of that timer's step in the same cycle, so any enable arriving in that cycle is lost.
- R8: Pair k (timers k and k+1, k = 0..2) is active only when control bit k and control bit 24+k are both 1. When the lower timer of an active pair steps at zero, it loads 0xFFFF_FFFF, raises no interrupt, and gives the upper timer exactly one step.
- R9: The upper timer of an active pair ignores the prescaler. It changes only on wraps of its lower timer, and it keeps its own reload and interrupt behaviour.
- R10: Addresses are byte addresses. Timer n occupies 0x40·n to 0x40·n+0x3F. Its count register is at +0x00, its reload register at +0x10, its vector word at +0x20 and its destination word at +0x30. The control word is at 0x100. Vector and destination words store and return all 32 bits.
- R11: Only control bits [26:24], [9:8] and [2:0] can be written, and the other control bits always read 0. A read of any other address returns 0. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_n | output | 4 | Per-timer interrupt level, active low |

## Verification
If the prescaler phase is wrong, every running timer shows it at the count port. Within one enable period, every later count reading is off by one step. A wrong chain decision shows up in two ways at the ports. The upper timer's count moves on prescaler enables, or the lower timer reloads to a small value instead of 0xFFFF_FFFF. Either is visible in the first step after the lower timer reaches zero. A lost or stuck interrupt flag appears directly on irq_n. The bench compares irq_n against a reference model every cycle, so such an error is caught in the cycle where it first occurs.

// File: rtl/tgrp_pkg.sv
// Shared definitions for the cascadable timer group.
// Assumes byte addressing with one 64-byte window per timer and
// 16-byte spacing between the registers inside that window.
package tgrp_pkg;

    localparam int unsigned TG_TIMER_SPAN = 64;
    localparam int unsigned TG_REG_STRIDE = 16;
    localparam int unsigned TG_REG_LSB    = $clog2(TG_REG_STRIDE);
    localparam int unsigned TG_TMR_LSB    = $clog2(TG_TIMER_SPAN);

    // Register slot inside a timer window; the order sets the address.
    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_VECTOR = 2'd2,
        REG_DEST   = 2'd3
    } tg_reg_e;

endpackage

// File: rtl/tgrp_prescaler.sv
// Shared clock prescaler for the timer group.
// A counter that runs freely from reset. It gives a one-cycle enable
// whenever its low BASE_LOG2+sel bits are all ones.
// Assumes sel can change at any time; the new ratio applies at once.
module tgrp_prescaler #(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;
    localparam int unsigned SH_W  = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  shamt;
    logic [CNT_W:0]   limit;
    logic [CNT_W:0]   mask_full;
    logic [CNT_W-1:0] mask;

    // Build the mask of low bits that the selected ratio looks at.
    always_comb begin
        shamt     = SH_W'(BASE_LOG2) + SH_W'(sel);
        limit     = (CNT_W+1)'(1) << shamt;
        mask_full = limit - (CNT_W+1)'(1);
        mask      = mask_full[CNT_W-1:0];
        tick      = ((cnt_q & mask) == mask);
    end

    // Count freely; the counter only restarts on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2: the ratio is at least 8, so two enables are never adjacent.
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tgrp_channel.sv
// One timer channel of the group.
// Holds the count, the reload word (its top bit is the inhibit flag),
// two routing storage words and the interrupt flag.
// step_in is the enable from the prescaler or from the channel below.
// chain_up says this channel is the lower half of an active pair.
// A register write to count or reload replaces the step in that cycle.
module tgrp_channel #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_in,
    input  logic          chain_up,
    input  logic          cnt_we,
    input  logic          reload_we,
    input  logic          vec_we,
    input  logic          dst_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] reload_o,
    output logic [DW-1:0] vec_o,
    output logic [DW-1:0] dst_o,
    output logic          wrap_o,
    output logic          irq_n_o
);
    localparam int unsigned INH = DW - 1;

    logic [DW-1:0] count_q;
    logic [DW-1:0] reload_q;
    logic [DW-1:0] vec_q;
    logic [DW-1:0] dst_q;
    logic          pend_q;
    logic          active;
    logic          at_zero;
    logic          expire;

    // Decide whether this channel steps, wraps or expires this cycle.
    always_comb begin
        active  = step_in && !reload_q[INH] && !cnt_we && !reload_we;
        at_zero = (count_q == '0);
        wrap_o  = active && at_zero && chain_up;
        expire  = active && at_zero && !chain_up;
    end

    // Update the count: a write first, then a decrement, a wrap or a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_we) begin
            count_q <= wdata;
        end else if (reload_we && wdata[INH]) begin
            count_q <= {1'b0, wdata[INH-1:0]};
        end else if (active) begin
            if (!at_zero)      count_q <= count_q - DW'(1);
            else if (chain_up) count_q <= '1;
            else               count_q <= {1'b0, reload_q[INH-1:0]};
        end
    end

    // Hold the reload word; reset leaves the channel inhibited.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= {1'b1, {(DW-1){1'b0}}};
        else if (reload_we) reload_q <= wdata;
    end

    // Keep the two routing words as plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            dst_q <= '0;
        end else begin
            if (vec_we) vec_q <= wdata;
            if (dst_we) dst_q <= wdata;
        end
    end

    // Set the interrupt flag on expiry; a count write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (cnt_we) pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign vec_o    = vec_q;
    assign dst_o    = dst_q;
    assign irq_n_o  = !pend_q;

    // R3: an inhibited channel that is not written keeps its count.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q[INH] && !cnt_we && !reload_we) |=> $stable(count_o));

    // R4: the interrupt line falls only after a step at count zero.
    a_r4_irq_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(count_o == '0));

    // R5: the interrupt line rises only after a count write.
    a_r5_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n_o) |-> $past(cnt_we));

    // R8: a wrap leaves the lower channel at all ones.
    a_r8_wrap_fill: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '1));

endmodule

// File: rtl/tgrp_timer_group.sv
// Four-channel cascadable timer group, top level.
// Decodes the register port, keeps the group control word and drives
// the prescaler and the channels. Neighbouring channels can be chained
// into pairs through the control word.
// Assumes at most one write per cycle; reads are combinational.
module tgrp_timer_group
    import tgrp_pkg::*;
#(
    parameter int unsigned NUM_TIMERS  = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned ROLL_SHIFT  = 24,
    parameter int unsigned DIV_SEL_LSB = 8,
    parameter int unsigned DIV_SEL_W   = 2,
    parameter int unsigned DIV_BASE    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_TIMERS-1:0] irq_n
);
    localparam int unsigned NPAIR  = NUM_TIMERS - 1;
    localparam int unsigned TIDX_W = $clog2(NUM_TIMERS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_TIMERS * TG_TIMER_SPAN);
    localparam logic [DATA_W-1:0] PAIR_BITS = DATA_W'((1 << NPAIR) - 1);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        PAIR_BITS | (PAIR_BITS << ROLL_SHIFT) |
        (DATA_W'((1 << DIV_SEL_W) - 1) << DIV_SEL_LSB);

    logic [DATA_W-1:0]     ctrl_q;
    logic                  tick;
    logic [NPAIR-1:0]      pair_on;
    logic [NUM_TIMERS-1:0] step;
    logic [NUM_TIMERS-1:0] chain;
    logic [NUM_TIMERS-1:0] wrap;
    logic [NUM_TIMERS-1:0] cnt_we;
    logic [NUM_TIMERS-1:0] reload_we;
    logic [NUM_TIMERS-1:0] vec_we;
    logic [NUM_TIMERS-1:0] dst_we;
    logic [DATA_W-1:0]     count_a  [NUM_TIMERS];
    logic [DATA_W-1:0]     reload_a [NUM_TIMERS];
    logic [DATA_W-1:0]     vec_a    [NUM_TIMERS];
    logic [DATA_W-1:0]     dst_a    [NUM_TIMERS];

    logic              wr_tmr;
    logic [TIDX_W-1:0] wr_tsel;
    tg_reg_e           wr_rsel;
    logic              rd_tmr;
    logic [TIDX_W-1:0] rd_tsel;
    tg_reg_e           rd_rsel;

    // Split both addresses into a timer index and a register slot.
    always_comb begin
        wr_tmr  = (wr_addr < CTRL_ADDR) && (wr_addr[TG_REG_LSB-1:0] == '0);
        wr_tsel = wr_addr[TG_TMR_LSB +: TIDX_W];
        wr_rsel = tg_reg_e'(wr_addr[TG_REG_LSB +: 2]);
        rd_tmr  = (rd_addr < CTRL_ADDR) && (rd_addr[TG_REG_LSB-1:0] == '0);
        rd_tsel = rd_addr[TG_TMR_LSB +: TIDX_W];
        rd_rsel = tg_reg_e'(rd_addr[TG_REG_LSB +: 2]);
    end

    // Turn a write into one strobe for the addressed register.
    always_comb begin
        for (int n = 0; n < NUM_TIMERS; n++) begin
            cnt_we[n]    = wr_en && wr_tmr && (wr_tsel == TIDX_W'(n)) && (wr_rsel == REG_COUNT);
            reload_we[n] = wr_en && wr_tmr && (wr_tsel == TIDX_W'(n)) && (wr_rsel == REG_RELOAD);
            vec_we[n]    = wr_en && wr_tmr && (wr_tsel == TIDX_W'(n)) && (wr_rsel == REG_VECTOR);
            dst_we[n]    = wr_en && wr_tmr && (wr_tsel == TIDX_W'(n)) && (wr_rsel == REG_DEST);
        end
    end

    // Store the writable control bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (wr_en && wr_addr == CTRL_ADDR) ctrl_q <= wr_data & CTRL_MASK;
    end

    tgrp_prescaler #(
        .SEL_W     (DIV_SEL_W),
        .BASE_LOG2 (DIV_BASE)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q[DIV_SEL_LSB +: DIV_SEL_W]),
        .tick  (tick)
    );

    // A pair is active only when its chain bit and its wrap bit are both set.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign pair_on[k] = ctrl_q[k] & ctrl_q[ROLL_SHIFT + k];
    end

    // Choose each channel's step source and build the channels.
    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_chan
        if (n == 0) begin : g_first
            assign step[n] = tick;
        end else begin : g_next
            assign step[n] = pair_on[n-1] ? wrap[n-1] : tick;
        end

        if (n < NPAIR) begin : g_low
            assign chain[n] = pair_on[n];
        end else begin : g_top
            assign chain[n] = 1'b0;
        end

        tgrp_channel #(
            .DW (DATA_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_in   (step[n]),
            .chain_up  (chain[n]),
            .cnt_we    (cnt_we[n]),
            .reload_we (reload_we[n]),
            .vec_we    (vec_we[n]),
            .dst_we    (dst_we[n]),
            .wdata     (wr_data),
            .count_o   (count_a[n]),
            .reload_o  (reload_a[n]),
            .vec_o     (vec_a[n]),
            .dst_o     (dst_a[n]),
            .wrap_o    (wrap[n]),
            .irq_n_o   (irq_n[n])
        );
    end

    // Return the addressed register; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) begin
            rd_data = ctrl_q;
        end else if (rd_tmr) begin
            case (rd_rsel)
                REG_COUNT:  rd_data = count_a[rd_tsel];
                REG_RELOAD: rd_data = reload_a[rd_tsel];
                REG_VECTOR: rd_data = vec_a[rd_tsel];
                REG_DEST:   rd_data = dst_a[rd_tsel];
                default:    rd_data = '0;
            endcase
        end
    end

    // R9: the upper half of an active pair steps only on a wrap from below.
    a_r9_upper_source: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_on[0] && !wrap[0]) |-> !step[1]);

    // R11: bits outside the writable set never read back as 1.
    a_r11_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CTRL_ADDR) |-> ((rd_data & ~CTRL_MASK) == '0));

endmodule

// File: tb/tgrp_timer_group_test.sv
// Bench for the timer group: directed corner cases, then random traffic
// with a fixed seed. A cycle-by-cycle reference model supplies the
// expected values.
module tgrp_timer_group_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [8:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] rd_seen;

    always #10 clk = ~clk;

    tgrp_timer_group uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_cnt [4];
    logic [31:0] m_rel [4];
    logic [31:0] m_vec [4];
    logic [31:0] m_dst [4];
    logic [3:0]  m_pend;
    logic [31:0] m_ctrl;
    logic [5:0]  m_pc;
    logic        m_tick, m_step, m_chain, m_act, m_zero, m_carry, m_wc, m_wb;

    function automatic logic [5:0] pmask(input logic [1:0] s);
        logic [6:0] t;
        t = (7'd8 << s) - 7'd1;
        return t[5:0];
    endfunction

    function automatic logic [31:0] m_read(input logic [8:0] a);
        int t;
        if (a == 9'h100) return m_ctrl;
        if (a < 9'h100 && a[3:0] == 4'h0) begin
            t = int'(a[7:6]);
            case (a[5:4])
                2'd0: return m_cnt[t];
                2'd1: return m_rel[t];
                2'd2: return m_vec[t];
                default: return m_dst[t];
            endcase
        end
        return 32'h0;
    endfunction

    function automatic string rd_tag(input logic [8:0] a);
        if (a == 9'h100) return "R11 control read";
        if (a < 9'h100 && a[3:0] == 4'h0) begin
            case (a[5:4])
                2'd0: return "R4 count read";
                2'd1: return "R6 reload read";
                default: return "R10 storage read";
            endcase
        end
        return "R11 unmapped read";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = '0; m_ctrl = '0; m_pend = '0;
            for (int n = 0; n < 4; n++) begin
                m_cnt[n] = '0; m_rel[n] = 32'h8000_0000; m_vec[n] = '0; m_dst[n] = '0;
            end
        end else begin
            m_tick  = ((m_pc & pmask(m_ctrl[9:8])) == pmask(m_ctrl[9:8]));
            m_pc    = m_pc + 6'd1;
            m_carry = 1'b0;
            for (int n = 0; n < 4; n++) begin
                if (n > 0 && m_ctrl[n-1] && m_ctrl[24+n-1]) m_step = m_carry;
                else                                        m_step = m_tick;
                m_chain = (n < 3) && m_ctrl[n] && m_ctrl[24+n];
                m_wc    = wr_en && wr_addr == 9'(n*64);
                m_wb    = wr_en && wr_addr == 9'(n*64 + 16);
                m_act   = m_step && !m_rel[n][31] && !m_wc && !m_wb;
                m_zero  = (m_cnt[n] == 32'h0);
                m_carry = m_act && m_zero && m_chain;
                if (m_wc) begin
                    m_cnt[n] = wr_data; m_pend[n] = 1'b0;
                end else if (m_wb && wr_data[31]) begin
                    m_cnt[n] = {1'b0, wr_data[30:0]};
                end else if (m_act) begin
                    if (!m_zero)      m_cnt[n] = m_cnt[n] - 32'd1;
                    else if (m_chain) m_cnt[n] = 32'hFFFF_FFFF;
                    else begin
                        m_cnt[n] = {1'b0, m_rel[n][30:0]}; m_pend[n] = 1'b1;
                    end
                end
                if (m_wb) m_rel[n] = wr_data;
                if (wr_en && wr_addr == 9'(n*64 + 32)) m_vec[n] = wr_data;
                if (wr_en && wr_addr == 9'(n*64 + 48)) m_dst[n] = wr_data;
            end
            if (wr_en && wr_addr == 9'h100) m_ctrl = wr_data & 32'h0700_0307;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive one cycle of inputs and check the state left by the previous edge.
    task automatic cyc(input bit we, input logic [8:0] wa, input logic [31:0] wd,
                       input logic [8:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        #2;
        rd_seen = rd_data;
        check(rd_tag(ra), rd_data, m_read(ra));
        check("R5 irq level", {28'h0, irq_n}, {28'h0, ~m_pend});
    endtask

    task automatic idle(input int n, input logic [8:0] ra);
        for (int i = 0; i < n; i++) cyc(1'b0, 9'h0, 32'h0, ra);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        bit saw_ones;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc(1'b0, 9'h0, 32'h0, 9'h010);
        check("R1 reload after reset", rd_seen, 32'h8000_0000);
        check("R1 irq after reset", {28'h0, irq_n}, 32'hF);
        cyc(1'b0, 9'h0, 32'h0, 9'h100);
        check("R1 control after reset", rd_seen, 32'h0);
        cyc(1'b0, 9'h0, 32'h0, 9'h0C0);
        check("R1 count after reset", rd_seen, 32'h0);

        // R11 control mask and unmapped space
        cyc(1'b1, 9'h100, 32'hFFFF_FFFF, 9'h100);
        cyc(1'b1, 9'h104, 32'h1234_5678, 9'h100);
        check("R11 control writable bits", rd_seen, 32'h0700_0307);
        cyc(1'b1, 9'h100, 32'h0, 9'h104);
        check("R11 unmapped read", rd_seen, 32'h0);
        cyc(1'b0, 9'h0, 32'h0, 9'h008);
        check("R11 misaligned read", rd_seen, 32'h0);

        // R10 storage words
        cyc(1'b1, 9'h0A0, 32'hDEAD_BEEF, 9'h0);
        cyc(1'b1, 9'h070, 32'h0BAD_F00D, 9'h0A0);
        check("R10 vector word timer 2", rd_seen, 32'hDEAD_BEEF);
        cyc(1'b0, 9'h0, 32'h0, 9'h070);
        check("R10 destination word timer 1", rd_seen, 32'h0BAD_F00D);

        // R6 and R7 reload-write behaviour
        cyc(1'b1, 9'h010, 32'h8000_0005, 9'h000);
        cyc(1'b1, 9'h010, 32'h0000_0009, 9'h000);
        check("R6 inhibited reload loads count", rd_seen, 32'h5);
        cyc(1'b0, 9'h0, 32'h0, 9'h000);
        check("R7 reload write holds count", rd_seen, 32'h5);

        // R3 inhibit holds count
        cyc(1'b1, 9'h090, 32'h8000_0009, 9'h080);
        idle(100, 9'h080);
        check("R3 inhibited count held", rd_seen, 32'h9);
        check("R3 inhibited no irq", {31'h0, irq_n[2]}, 32'h1);

        // R4 standalone reload and interrupt, divide by 8
        cyc(1'b1, 9'h010, 32'h8000_0002, 9'h000);
        cyc(1'b1, 9'h010, 32'h0000_0002, 9'h000);
        idle(25, 9'h000);
        check("R4 reload after expiry", rd_seen, 32'h2);
        check("R4 irq asserted", {31'h0, irq_n[0]}, 32'h0);
        // R5 count write releases the line
        cyc(1'b1, 9'h000, 32'h0000_0040, 9'h000);
        cyc(1'b1, 9'h010, 32'h8000_0040, 9'h000);
        check("R5 count write value", rd_seen, 32'h40);
        check("R5 irq released", {31'h0, irq_n[0]}, 32'h1);

        // R2 divide by 16 on timer 3
        cyc(1'b1, 9'h100, 32'h0000_0100, 9'h0C0);
        cyc(1'b1, 9'h0D0, 32'h8000_0032, 9'h0C0);
        cyc(1'b1, 9'h0D0, 32'h0000_0032, 9'h0C0);
        idle(161, 9'h0C0);
        check("R2 divide by 16 count", rd_seen, 32'd40);
        cyc(1'b1, 9'h0D0, 32'h8000_0032, 9'h0C0);

        // R8 and R9 pair 0 chaining
        cyc(1'b1, 9'h100, 32'h0100_0001, 9'h0);
        cyc(1'b1, 9'h050, 32'h8000_0004, 9'h0);
        cyc(1'b1, 9'h010, 32'h8000_0005, 9'h0);
        cyc(1'b1, 9'h050, 32'h0000_0004, 9'h0);
        cyc(1'b1, 9'h010, 32'h0000_0007, 9'h0);
        idle(24, 9'h040);
        cyc(1'b0, 9'h0, 32'h0, 9'h040);
        check("R9 upper ignores prescaler", rd_seen, 32'h4);
        saw_ones = 1'b0;
        for (int i = 0; i < 39; i++) begin
            cyc(1'b0, 9'h0, 32'h0, 9'h000);
            if (rd_seen[31:4] == 28'hFFFF_FFF) saw_ones = 1'b1;
            check("R8 lower raises no irq", {31'h0, irq_n[0]}, 32'h1);
        end
        cyc(1'b0, 9'h0, 32'h0, 9'h000);
        check("R8 lower wraps to all ones", rd_seen, 32'hFFFF_FFFD);
        cyc(1'b0, 9'h0, 32'h0, 9'h040);
        check("R9 upper stepped by wrap", rd_seen, 32'h3);
        check("R8 wrap observed", {31'h0, saw_ones}, 32'h1);
        for (int w = 0; w < 4; w++) begin
            cyc(1'b1, 9'h000, 32'h0, 9'h040);
            idle(9, 9'h040);
        end
        check("R9 upper reloaded after wraps", rd_seen, 32'h4);
        check("R9 upper irq", {31'h0, irq_n[1]}, 32'h0);

        // Random traffic
        for (int i = 0; i < 15000; i++) begin
            logic [8:0]  wa, ra;
            logic [31:0] wd;
            bit          we;
            int          kind;
            we = ($urandom % 5) < 2;
            kind = int'($urandom % 9);
            wa = {1'b0, 2'($urandom), 2'($urandom), 4'h0};
            wd = $urandom;
            case (kind)
                0, 1, 2: begin
                    wa[5:4] = 2'd0;
                    wd = (($urandom % 8) == 0) ? $urandom : ($urandom % 48);
                end
                3, 4, 5: begin
                    wa[5:4] = 2'd1;
                    wd = ((($urandom % 3) == 0) ? 32'h8000_0000 : 32'h0) | ($urandom % 48);
                end
                6: wa[5] = 1'b1;
                7: wa = 9'h100;
                default: wa = 9'($urandom);
            endcase
            if (($urandom % 2) == 0) ra = (($urandom % 8) == 0) ? 9'h100
                                          : {1'b0, 2'($urandom), 2'($urandom), 4'h0};
            else ra = 9'($urandom);
            cyc(we, wa, wd, ra);
        end

        cyc(1'b0, 9'h0, 32'h0, 9'h100);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule